// File: doc/BRIEF.md
# Address-Stability Sleep Controller

This block sits in the read path of a parallel memory. It compares the address bus on each clock with the value it registered on the cycle before. A counter measures how long the address has stayed the same. When that run reaches the access latency plus a fixed extra margin, the read path drops into a low-power sleep state. The chip-select, write and output-enable strobes play no part in entering or leaving sleep.

The block captures the array read word at the point where the access latency runs out. It then keeps driving that word onto the data output for as long as the address stays put, including the whole of any sleep period. As soon as the address moves, sleep ends in that same cycle and the data-valid flag drops. Fresh data appears after the normal access latency.

The margin is set in picoseconds together with the clock period and is rounded up to whole cycles. An option selects what the data output shows while the data is not valid: either the last captured word, or zero.

Top module: `asc_sleep_ctrl`

## Requirements
- R1: While the active-low reset is low, `sleep_o`, `valid_o` and `data_o` are all zero. Reset also clears the stability count, so the timing in R3 and R5 starts again from the first edge after release.
- R2: The stability count restarts on every clock edge at which `addr_i` differs from the address registered at the previous edge. A run of unchanged address cycles that is shorter than the sleep threshold therefore never raises `sleep_o`.
- R3: `valid_o` is low during any cycle in which `addr_i` differs from the registered address. It rises after exactly `ACCESS_CYC` further rising edges with the address held.
- R4: When `valid_o` rises, `data_o` equals the `rd_data_i` value that was present at the rising edge just before.
- R5: `sleep_o` rises after exactly `ACCESS_CYC + MARGIN_CYC` rising edges with the address held. `MARGIN_CYC` is `MARGIN_PS / CLK_PERIOD_PS`, rounded up.
- R6: `sleep_o` and `valid_o` fall in the same cycle in which `addr_i` changes. They do not wait for a clock edge.
- R7: `chip_sel_n_i`, `write_n_i` and `out_en_n_i` have no effect on `sleep_o`, `valid_o` or `data_o`.
- R8: While the address is held after capture, including all of sleep, `data_o` keeps the captured word even if `rd_data_i` changes.
- R9: With `INVALID_POLICY = BLANK_ZERO`, `data_o` is zero in every cycle in which `valid_o` is low. With the default `HOLD_STALE`, `data_o` keeps showing the last captured word in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Memory address bus |
| chip_sel_n_i | input | 1 | Chip select, active low (has no effect on sleep) |
| write_n_i | input | 1 | Write strobe, active low (has no effect on sleep) |
| out_en_n_i | input | 1 | Output enable, active low (has no effect on sleep) |
| rd_data_i | input | DATA_W | Read data from the array |
| data_o | output | DATA_W | Latched read data |
| sleep_o | output | 1 | High while the read path sleeps |
| valid_o | output | 1 | High when `data_o` belongs to the current address |

## Verification
The hardest case to reach is a change of the array data while the block is asleep. Only a real change at that point shows whether the latch is truly frozen, or whether it is simply re-capturing a word that happens not to have changed. The bench's array model mixes a key into every word. It changes that key only in cycles where the expected count is already past the sleep threshold, and then checks that `data_o` still shows the word formed with the old key. The bench also sweeps the hold length from one cycle up to past the threshold, for a series of addresses. This places an address change at every possible count value, including one cycle before capture and one cycle before sleep.

// File: rtl/asc_sleep_pkg.sv
package asc_sleep_pkg;

   typedef enum logic {
      HOLD_STALE = 1'b0,
      BLANK_ZERO = 1'b1
   } invalid_policy_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/asc_addr_watch.sv
module asc_addr_watch #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              moved_o
);

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else begin
         addr_q <= addr_i;
      end
   end

   assign moved_o = (addr_i != addr_q);

endmodule

// File: rtl/asc_stab_timer.sv
module asc_stab_timer #(
   parameter int ACCESS_CYC = 4,
   parameter int SLEEP_AT   = 7,
   parameter int CNT_W      = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             moved_i,
   output logic             ready_o,
   output logic             doze_o,
   output logic             capture_o
);

   localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(SLEEP_AT);
   localparam logic [CNT_W-1:0] ACC_CNT = CNT_W'(ACCESS_CYC);
   localparam logic [CNT_W-1:0] CAP_CNT = CNT_W'(ACCESS_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (moved_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LIMIT) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ready_o   = !moved_i && (cnt_q >= ACC_CNT);
   assign doze_o    = !moved_i && (cnt_q == LIMIT);
   assign capture_o = !moved_i && (cnt_q == CAP_CNT);

   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      moved_i |=> (cnt_q == '0)); // R2

   AST_VALID_RISE_AT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> ($past(cnt_q) == CAP_CNT)); // R3

   AST_SLEEP_RISE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(doze_o) |-> ($past(cnt_q) == LIMIT - 1'b1)); // R5

   AST_SLEEP_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      doze_o |-> ready_o); // R5

endmodule

// File: rtl/asc_data_hold.sv
module asc_data_hold
   import asc_sleep_pkg::*;
#(
   parameter int              DATA_W = 16,
   parameter invalid_policy_e POLICY = HOLD_STALE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic              valid_i,
   input  logic              doze_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [DATA_W-1:0] data_o
);

   logic [DATA_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (capture_i) begin
         word_q <= rd_data_i;
      end
   end

   generate
      if (POLICY == BLANK_ZERO) begin : g_blank
         assign data_o = valid_i ? word_q : '0;
      end else begin : g_hold
         assign data_o = word_q;
      end
   endgenerate

   AST_HOLD_WHILE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (doze_i && $past(doze_i)) |-> $stable(word_q)); // R8

   AST_NO_CAPTURE_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |-> !capture_i); // R8

endmodule

// File: rtl/asc_sleep_ctrl.sv
module asc_sleep_ctrl
   import asc_sleep_pkg::*;
#(
   parameter int              ADDR_W         = 8,
   parameter int              DATA_W         = 16,
   parameter int              ACCESS_CYC     = 4,
   parameter int              CLK_PERIOD_PS  = 10000,
   parameter int              MARGIN_PS      = 30000,
   parameter invalid_policy_e INVALID_POLICY = HOLD_STALE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              chip_sel_n_i,
   input  logic              write_n_i,
   input  logic              out_en_n_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [DATA_W-1:0] data_o,
   output logic              sleep_o,
   output logic              valid_o
);

   localparam int MARGIN_CYC = ceil_div(MARGIN_PS, CLK_PERIOD_PS);
   localparam int SLEEP_AT   = ACCESS_CYC + MARGIN_CYC;
   localparam int CNT_W      = $clog2(SLEEP_AT + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("asc_sleep_ctrl: widths must be at least one bit");
      end
      if (ACCESS_CYC < 1) begin : g_bad_latency
         $error("asc_sleep_ctrl: ACCESS_CYC must be at least 1");
      end
      if (CLK_PERIOD_PS < 1 || MARGIN_PS < 0) begin : g_bad_timing
         $error("asc_sleep_ctrl: clock period must be positive, margin non-negative");
      end
   endgenerate

   logic moved;
   logic capture;
   logic [2:0] strobes;

   assign strobes = {chip_sel_n_i, write_n_i, out_en_n_i};

   asc_addr_watch #(
      .ADDR_W (ADDR_W)
   ) u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (addr_i),
      .moved_o (moved)
   );

   asc_stab_timer #(
      .ACCESS_CYC (ACCESS_CYC),
      .SLEEP_AT   (SLEEP_AT),
      .CNT_W      (CNT_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .moved_i   (moved),
      .ready_o   (valid_o),
      .doze_o    (sleep_o),
      .capture_o (capture)
   );

   asc_data_hold #(
      .DATA_W (DATA_W),
      .POLICY (INVALID_POLICY)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .valid_i   (valid_o),
      .doze_i    (sleep_o),
      .rd_data_i (rd_data_i),
      .data_o    (data_o)
   );

   AST_WAKE_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sleep_o) && moved) |-> (!sleep_o && !valid_o)); // R6

   AST_STROBE_BLIND: assert property (@(posedge clk) disable iff (!rst_n)
      ((strobes != $past(strobes)) && $past(sleep_o) && !moved) |-> sleep_o); // R7

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!sleep_o && !valid_o && (data_o == '0))); // R1

endmodule

// File: tb/tb_asc_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_asc_sleep_ctrl;
   import asc_sleep_pkg::*;

   localparam int ACC      = 4;
   localparam int MARGIN   = 3;   // 30000 ps at 10000 ps, rounded up
   localparam int SLEEP_AT = ACC + MARGIN;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [2:0]  strb = 3'b111;
   logic [7:0]  key = 8'h00;
   logic [15:0] rd_data;
   logic [15:0] data_h, data_z;
   logic        sleep_h, sleep_z, valid_h, valid_z;
   logic [15:0] exp_data = 16'h0000;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   assign rd_data = {addr ^ key, ~addr};

   asc_sleep_ctrl #(.ADDR_W(8), .DATA_W(16), .ACCESS_CYC(ACC),
                    .CLK_PERIOD_PS(10000), .MARGIN_PS(30000),
                    .INVALID_POLICY(HOLD_STALE)) dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr),
      .chip_sel_n_i(strb[2]), .write_n_i(strb[1]), .out_en_n_i(strb[0]),
      .rd_data_i(rd_data), .data_o(data_h), .sleep_o(sleep_h), .valid_o(valid_h));

   asc_sleep_ctrl #(.ADDR_W(8), .DATA_W(16), .ACCESS_CYC(ACC),
                    .CLK_PERIOD_PS(10000), .MARGIN_PS(30000),
                    .INVALID_POLICY(BLANK_ZERO)) dut_z (
      .clk(clk), .rst_n(rst_n), .addr_i(addr),
      .chip_sel_n_i(~strb[2]), .write_n_i(strb[0]), .out_en_n_i(strb[1]),
      .rd_data_i(rd_data), .data_o(data_z), .sleep_o(sleep_z), .valid_o(valid_z));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
      end
   endtask

   task automatic check_all(input bit exp_valid, input bit exp_sleep);
      chk(valid_h == exp_valid, "R3 valid", valid_h, exp_valid);
      chk(valid_z == exp_valid, "R7 valid blind to strobes", valid_z, exp_valid);
      chk(sleep_h == exp_sleep, "R2/R5/R6 sleep", sleep_h, exp_sleep);
      chk(sleep_z == exp_sleep, "R7 sleep blind to strobes", sleep_z, exp_sleep);
      chk(data_h == exp_data, "R4/R8 data", data_h, exp_data);
      chk(data_z == (exp_valid ? exp_data : 16'h0), "R9 blanked data", data_z,
          exp_valid ? exp_data : 16'h0);
   endtask

   // Drive a new address at a falling edge and hold it for 'hold' edges.
   task automatic present(input logic [7:0] a, input int hold, input bit poke_key);
      addr = a;
      strb = strb + 3'd5;
      #1;
      check_all(1'b0, 1'b0);   // R6: change drops sleep and valid at once
      for (int i = 1; i <= hold; i++) begin
         @(negedge clk);
         if (i == ACC + 1) exp_data = {a ^ key, ~a};   // R4
         check_all((i - 1) >= ACC, (i - 1) >= SLEEP_AT);
         strb = strb + 3'd3;                           // R7
         if (poke_key && (i - 1) >= SLEEP_AT) key = key + 8'h5b;   // R8
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] a;
      repeat (3) begin
         @(negedge clk);
         chk(!sleep_h && !valid_h && data_h == 16'h0, "R1 reset", {sleep_h, valid_h, data_h},
             32'h0);
         chk(data_z == 16'h0, "R1 reset blank", data_z, 32'h0);
      end
      rst_n = 1'b1;
      a = 8'h11;
      // Sweep hold lengths through every count value, with key changes in sleep.
      for (int r = 0; r < 6; r++) begin
         for (int h = 1; h <= SLEEP_AT + 3; h++) begin
            a = a + 8'd29;
            present(a, h, (r % 2) == 1);
         end
      end
      // Long sleep with many key changes, then reset mid-sleep.
      a = a + 8'd29;
      present(a, SLEEP_AT + 10, 1'b1);
      rst_n = 1'b0;
      #1;
      exp_data = 16'h0;
      chk(!sleep_h && !valid_h, "R1 reset during sleep", {sleep_h, valid_h}, 32'h0);
      chk(data_h == 16'h0 && data_z == 16'h0, "R1 reset clears data", data_h, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int h = 1; h <= SLEEP_AT + 2; h++) begin
         a = a + 8'd29;
         present(a, h, 1'b1);
      end
      a = a + 8'd29;
      present(a, SLEEP_AT + 4, 1'b1);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule